// File: doc/BRIEF.md
# Latency-Configurable Pipelined Integer Multiplier

This block multiplies two integer operands and returns the full-width product after a fixed number of clock cycles. A single parameter sets that number, and it may be zero or larger. The block places its registers at three kinds of site. The output site is filled first, then the input site, and any further cycles go to a delay line behind the partial-product stage. This lets a designer trade latency against logic depth by changing one value. Callers never need to know where the registers went.

Each operand pair arrives with a valid strobe and a small tag. The tag carries whatever control the caller needs to stay attached to the result. Valid and tag travel through a control chain that has exactly as many stages as the data path, so they always emerge next to the product they belong to. The pipeline never stalls and accepts a new beat on every clock. One parameter chooses unsigned or two's-complement operation.

Top module: `lat_mult`

## Requirements
- R1: For every clock edge at which `inValid` is high, `outValid` is high exactly `LATENCY` cycles later. `outValid` is never high at any other time.
- R2: With `SIGNED_OPS`=0, `prodOut` is the full unsigned product of `aIn` and `bIn`, `A_W+B_W` bits wide with no truncation. Example: 255×255 = 65025.
- R3: With `SIGNED_OPS`=1, both operands and the product are two's complement. Example: 0x80×0x80 = 16384, and 0x80×0x7F = 0xC080 (−16256).
- R4: `tagOut` on a valid output equals the `tagIn` presented with that beat.
- R5: `rst` is synchronous and active high. It clears every valid bit in the pipeline, so beats in flight are dropped. With `LATENCY`≥1, `outValid` is low in the cycle after reset.
- R6: With `LATENCY`=0 there are no registers in the path. `outValid`, `tagOut` and `prodOut` follow the inputs in the same cycle.
- R7: Operand and tag values presented while `inValid` is low change no product or tag that is delivered.
- R8: A new beat is accepted on every cycle. Back-to-back beats each produce their own correct result, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| inValid | input | 1 | Operand pair and tag are a beat |
| aIn | input | A_W | First operand |
| bIn | input | B_W | Second operand |
| tagIn | input | TAG_W | Sideband travelling with the beat |
| outValid | output | 1 | Product output holds a beat's result |
| prodOut | output | A_W+B_W | Full product |
| tagOut | output | TAG_W | Sideband of the delivered beat |

## Verification
Seven copies of the block run side by side: unsigned at latencies 0 to 5, and signed at latency 2. All copies see the same stimulus, so a placement error at one particular latency stands out against its neighbours.

The stimulus comes in four phases:
- Extreme operand pairs (zero, one, all-ones, the sign boundary). These separate zero from sign extension and expose truncation.
- Sparse beats with random data on the idle cycles. This shows that invalid cycles leave no trace in any result.
- A long unbroken burst. This shows full throughput and keeps each tag paired with its own product.
- A reset in the middle of a burst. This shows that beats in flight are dropped and that no stale valid leaks out afterwards.

// File: rtl/lat_mult_pkg.sv
`timescale 1ns/1ps
package lat_mult_pkg;

  // Register placement rule: output site first, input site second, rest middle.
  function automatic int outRegs(input int lat);
    return (lat >= 1) ? 1 : 0;
  endfunction

  function automatic int inRegs(input int lat);
    return ((lat - outRegs(lat)) >= 1) ? 1 : 0;
  endfunction

  function automatic int midRegs(input int lat);
    return lat - outRegs(lat) - inRegs(lat);
  endfunction

  // Load strobes from control to datapath for the single-register sites.
  typedef struct packed {
    logic inLoad;
    logic outLoad;
  } stageStrobe_t;

endpackage

// File: rtl/lat_mult_pp.sv
`timescale 1ns/1ps
// Partial-product generation and reduction into two half sums.
module lat_mult_pp #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter bit SIGNED_OPS = 1'b0,
  localparam int PW = A_W + B_W
) (
  input  logic [A_W-1:0] aOp,
  input  logic [B_W-1:0] bOp,
  output logic [PW-1:0]  lowSum,
  output logic [PW-1:0]  highSum
);

  localparam int HALF = B_W / 2;

  logic [PW-1:0] aWide;
  logic [B_W-1:0][PW-1:0] rows;

  assign aWide = SIGNED_OPS ? {{B_W{aOp[A_W-1]}}, aOp} : {{B_W{1'b0}}, aOp};

  for (genvar i = 0; i < B_W; i++) begin : gRow
    if (SIGNED_OPS && (i == B_W - 1)) begin : gNeg
      // The top bit of a two's-complement multiplier carries negative weight.
      assign rows[i] = bOp[i] ? (~(aWide << i)) + PW'(1) : '0;
    end else begin : gPos
      assign rows[i] = bOp[i] ? (aWide << i) : '0;
    end
  end

  always_comb begin
    lowSum = '0;
    for (int i = 0; i < HALF; i++) lowSum += rows[i];
  end

  always_comb begin
    highSum = '0;
    for (int i = HALF; i < B_W; i++) highSum += rows[i];
  end

endmodule

// File: rtl/lat_mult_ctrl.sv
`timescale 1ns/1ps
// Valid/tag chain matched to the data latency; emits per-site load strobes.
module lat_mult_ctrl
  import lat_mult_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int LATENCY = 3,
  localparam int MID_N = midRegs(LATENCY),
  localparam int MID_V = (MID_N > 0) ? MID_N : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [TAG_W-1:0] tagIn,
  output stageStrobe_t     strobes,
  output logic [MID_V-1:0] midLoad,
  output logic             outValid,
  output logic [TAG_W-1:0] tagOut
);

  localparam int IN_N = inRegs(LATENCY);

  if (LATENCY > 0) begin : gChain
    localparam int VW = LATENCY;
    logic [VW-1:0] vReg;
    logic [VW:0] vTap;
    logic [VW-1:0][TAG_W-1:0] tReg;
    logic [VW:0][TAG_W-1:0] tTap;

    // Tap k holds the valid/tag about to be captured by pipeline stage k+1.
    assign vTap = {vReg, inValid};
    assign tTap = {tReg, tagIn};

    always_ff @(posedge clk) begin
      if (rst) vReg <= '0;
      else     vReg <= vTap[VW-1:0];
      tReg <= tTap[VW-1:0];
    end

    assign strobes.inLoad  = (IN_N > 0) ? vTap[0] : 1'b0;
    assign strobes.outLoad = vTap[VW-1];

    if (MID_N > 0) begin : gMidStb
      for (genvar j = 0; j < MID_N; j++) begin : gMidBit
        assign midLoad[j] = vTap[IN_N + j];
      end
    end else begin : gNoMidStb
      assign midLoad = '0;
    end

    assign outValid = vTap[VW];
    assign tagOut   = tTap[VW];
  end else begin : gWire
    assign strobes  = '0;
    assign midLoad  = '0;
    assign outValid = inValid;
    assign tagOut   = tagIn;
  end

endmodule

// File: rtl/lat_mult_dp.sv
`timescale 1ns/1ps
// Multiplier datapath with registers at the sites chosen by the placement rule.
module lat_mult_dp
  import lat_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int LATENCY = 3,
  parameter bit SIGNED_OPS = 1'b0,
  localparam int PW = A_W + B_W,
  localparam int MID_N = midRegs(LATENCY),
  localparam int MID_V = (MID_N > 0) ? MID_N : 1
) (
  input  logic             clk,
  input  stageStrobe_t     strobes,
  input  logic [MID_V-1:0] midLoad,
  input  logic [A_W-1:0]   aIn,
  input  logic [B_W-1:0]   bIn,
  output logic [PW-1:0]    prodOut
);

  localparam int IN_N  = inRegs(LATENCY);
  localparam int OUT_N = outRegs(LATENCY);

  logic [A_W-1:0] aStage;
  logic [B_W-1:0] bStage;
  logic [PW-1:0] ppLo, ppHi;
  logic [MID_N:0][PW-1:0] loTap, hiTap;
  logic [PW-1:0] sumFinal;

  // Input site
  if (IN_N > 0) begin : gInReg
    always_ff @(posedge clk) begin
      if (strobes.inLoad) begin
        aStage <= aIn;
        bStage <= bIn;
      end
    end
  end else begin : gInPass
    assign aStage = aIn;
    assign bStage = bIn;
  end

  lat_mult_pp #(
    .A_W(A_W), .B_W(B_W), .SIGNED_OPS(SIGNED_OPS)
  ) u_pp (
    .aOp(aStage), .bOp(bStage), .lowSum(ppLo), .highSum(ppHi)
  );

  // Middle site: delay line of the two half sums
  if (MID_N > 0) begin : gMidReg
    logic [MID_N-1:0][PW-1:0] loReg, hiReg;
    assign loTap = {loReg, ppLo};
    assign hiTap = {hiReg, ppHi};
    for (genvar j = 0; j < MID_N; j++) begin : gMidStage
      always_ff @(posedge clk) begin
        if (midLoad[j]) begin
          loReg[j] <= loTap[j];
          hiReg[j] <= hiTap[j];
        end
      end
    end
  end else begin : gMidPass
    assign loTap = ppLo;
    assign hiTap = ppHi;
  end

  assign sumFinal = loTap[MID_N] + hiTap[MID_N];

  // Output site
  if (OUT_N > 0) begin : gOutReg
    always_ff @(posedge clk) begin
      if (strobes.outLoad) prodOut <= sumFinal;
    end
  end else begin : gOutPass
    assign prodOut = sumFinal;
  end

endmodule

// File: rtl/lat_mult.sv
`timescale 1ns/1ps
module lat_mult
  import lat_mult_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int TAG_W = 4,
  parameter int LATENCY = 3,
  parameter bit SIGNED_OPS = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [A_W-1:0]       aIn,
  input  logic [B_W-1:0]       bIn,
  input  logic [TAG_W-1:0]     tagIn,
  output logic                 outValid,
  output logic [A_W+B_W-1:0]   prodOut,
  output logic [TAG_W-1:0]     tagOut
);

  localparam int MID_N = midRegs(LATENCY);
  localparam int MID_V = (MID_N > 0) ? MID_N : 1;

  stageStrobe_t strobes;
  logic [MID_V-1:0] midLoad;

  lat_mult_ctrl #(
    .TAG_W(TAG_W), .LATENCY(LATENCY)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .tagIn(tagIn),
    .strobes(strobes), .midLoad(midLoad),
    .outValid(outValid), .tagOut(tagOut)
  );

  lat_mult_dp #(
    .A_W(A_W), .B_W(B_W), .LATENCY(LATENCY), .SIGNED_OPS(SIGNED_OPS)
  ) u_dp (
    .clk(clk), .strobes(strobes), .midLoad(midLoad),
    .aIn(aIn), .bIn(bIn), .prodOut(prodOut)
  );

endmodule

// File: rtl/lat_mult_chk.sv
`timescale 1ns/1ps
module lat_mult_chk #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int TAG_W = 4,
  parameter int LATENCY = 3,
  parameter bit SIGNED_OPS = 1'b0,
  localparam int PW = A_W + B_W
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [A_W-1:0]   aIn,
  input logic [B_W-1:0]   bIn,
  input logic [TAG_W-1:0] tagIn,
  input logic             outValid,
  input logic [PW-1:0]    prodOut,
  input logic [TAG_W-1:0] tagOut
);

  logic [PW-1:0] aExt, bExt, expNow;

  assign aExt = SIGNED_OPS ? {{B_W{aIn[A_W-1]}}, aIn} : {{B_W{1'b0}}, aIn};
  assign bExt = SIGNED_OPS ? {{A_W{bIn[B_W-1]}}, bIn} : {{A_W{1'b0}}, bIn};
  assign expNow = aExt * bExt;

  if (LATENCY > 0) begin : gSeq
    localparam int LW = LATENCY;
    logic [LW-1:0] vHist;
    logic [PW-1:0] pHist [LW];
    logic [TAG_W-1:0] tHist [LW];

    always_ff @(posedge clk) begin
      if (rst) vHist <= '0;
      else     vHist <= {vHist[LW-1:0], inValid} >> 0;
      pHist[0] <= expNow;
      tHist[0] <= tagIn;
      for (int k = 1; k < LW; k++) begin
        pHist[k] <= pHist[k-1];
        tHist[k] <= tHist[k-1];
      end
    end

    // R1: valid emerges exactly LATENCY cycles after each accepted beat
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
      outValid == vHist[LW-1]);

    // R2 (and R3 in signed mode): product of the matching beat
    assert_product_R2: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (prodOut == pHist[LW-1]));

    // R4: tag stays with its product
    assert_tag_aligned_R4: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (tagOut == tHist[LW-1]));

    // R5: nothing valid leaves right after reset
    assert_reset_flush_R5: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !outValid);
  end else begin : gComb
    // R6: zero latency passes straight through
    assert_comb_path_R6: assert property (@(posedge clk) disable iff (rst)
      (outValid == inValid) && (tagOut == tagIn) && (prodOut == expNow));
  end

endmodule

bind lat_mult lat_mult_chk #(
  .A_W(A_W), .B_W(B_W), .TAG_W(TAG_W), .LATENCY(LATENCY), .SIGNED_OPS(SIGNED_OPS)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .aIn(aIn), .bIn(bIn), .tagIn(tagIn),
  .outValid(outValid), .prodOut(prodOut), .tagOut(tagOut)
);

// File: tb/test_lat_mult.sv
`timescale 1ns/1ps
module test_lat_mult;

  typedef struct {
    logic [15:0] prod;
    logic [3:0]  tag;
    int          stamp;
    string       req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] aIn = '0;
  logic [7:0] bIn = '0;
  logic [3:0] tagIn = '0;
  string curReq = "R2";
  int cycleCount = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycleCount <= cycleCount + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  for (genvar g = 0; g < 7; g++) begin : gInst
    localparam int LAT = (g == 6) ? 2 : g;
    localparam bit SGN = (g == 6);
    logic outV;
    logic [15:0] prodO;
    logic [3:0] tagO;
    expItem_t q[$];

    lat_mult #(
      .A_W(8), .B_W(8), .TAG_W(4), .LATENCY(LAT), .SIGNED_OPS(SGN)
    ) i_lat_mult (
      .clk(clk), .rst(rst), .inValid(inValid), .aIn(aIn), .bIn(bIn), .tagIn(tagIn),
      .outValid(outV), .prodOut(prodO), .tagOut(tagO)
    );

    // capture: record what each accepted beat must produce
    always @(negedge clk) begin
      expItem_t it;
      longint p;
      #0.5;
      if (inValid && !rst) begin
        if (SGN) p = longint'($signed(aIn)) * longint'($signed(bIn));
        else     p = longint'(aIn) * longint'(bIn);
        it.prod  = p[15:0];
        it.tag   = tagIn;
        it.stamp = cycleCount + 1;
        it.req   = SGN ? "R3" : ((LAT == 0) ? "R6" : curReq);
        q.push_back(it);
      end
    end

    // reset drops everything in flight
    always @(posedge clk) if (rst) q.delete();

    // monitor
    always @(negedge clk) begin
      expItem_t it;
      int nextEdge;
      #1.25;
      if (!rst) begin
        nextEdge = cycleCount + 1;
        if (outV) begin
          if (q.size() == 0) begin
            chk(1'b0, "R1", $sformatf("lat%0d valid with no pending beat", LAT), 1, 0);
          end else begin
            it = q.pop_front();
            chk(it.stamp + LAT == nextEdge, "R1",
                $sformatf("lat%0d delivery edge", LAT), nextEdge, it.stamp + LAT);
            chk(prodO == it.prod, it.req,
                $sformatf("lat%0d product", LAT), prodO, it.prod);
            chk(tagO == it.tag, "R4",
                $sformatf("lat%0d tag", LAT), tagO, it.tag);
          end
        end else if (q.size() > 0 && q[0].stamp + LAT <= nextEdge) begin
          it = q.pop_front();
          chk(1'b0, "R1", $sformatf("lat%0d missing valid", LAT), 0, 1);
        end
      end
    end

    // R5: no valid right after any reset release
    always @(negedge rst) begin
      #1.25;
      chk(!outV, "R5", $sformatf("lat%0d valid after reset", LAT), outV, 0);
    end

    initial begin
      wait (done);
      chk(q.size() == 0, "R1", $sformatf("lat%0d beats never delivered", LAT), q.size(), 0);
    end
  end

  task automatic drive(input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] t, input logic v, input string req);
    @(negedge clk);
    aIn = a; bIn = b; tagIn = t; inValid = v; curReq = req;
  endtask

  task automatic doReset(input int n);
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    repeat (n - 1) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cycleCount, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] cA [10];
    logic [7:0] cB [10];
    cA = '{8'd0, 8'd0, 8'd255, 8'd1, 8'd255, 8'd128, 8'd127, 8'd1, 8'd128, 8'd200};
    cB = '{8'd0, 8'd255, 8'd255, 8'd1, 8'd1, 8'd128, 8'd128, 8'd255, 8'd127, 8'd3};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2/R3: extreme operand pairs, back to back
    for (int i = 0; i < 10; i++) drive(cA[i], cB[i], 4'(i), 1'b1, "R2");
    for (int i = 0; i < 6; i++) drive(8'h00, 8'h00, 4'h0, 1'b0, "R2");

    // R7: sparse beats, random garbage on idle cycles
    for (int i = 0; i < 30; i++) begin
      drive(8'($urandom), 8'($urandom), 4'($urandom), 1'b1, "R7");
      repeat (1 + (i % 3))
        drive(8'($urandom), 8'($urandom), 4'($urandom), 1'b0, "R7");
    end

    // R8: long unbroken burst
    for (int i = 0; i < 60; i++) drive(8'($urandom), 8'($urandom), 4'(i), 1'b1, "R8");
    for (int i = 0; i < 8; i++) drive(8'h00, 8'h00, 4'h0, 1'b0, "R8");

    // R5: reset in the middle of a burst
    for (int i = 0; i < 8; i++) drive(8'($urandom), 8'($urandom), 4'(i), 1'b1, "R5");
    doReset(2);
    for (int i = 0; i < 4; i++) drive(8'h00, 8'h00, 4'h0, 1'b0, "R5");
    for (int i = 0; i < 6; i++) drive(8'($urandom), 8'($urandom), 4'(i + 3), 1'b1, "R5");

    for (int i = 0; i < 12; i++) drive(8'h00, 8'h00, 4'h0, 1'b0, "R2");
    done = 1'b1;
    #20;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule